// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from the module clock. A 13-bit clock-control word holds two divisor fields and a mode bit. The linear law divides the module clock by 2*(N+1), where N is an 8-bit value. The exponential law divides it by 2^(N+1), where N is a 4-bit value. Between them they cover ratios from 2 to 65536.

The shift engine raises `active_i` for the length of an exchange. On the first cycle of an exchange the block captures the divisor, the mode and the idle polarity. From then on `sclk_o` toggles every half period with a 50% duty cycle. Each transition away from the idle level is marked by a one-cycle `lead_o` strobe, and each return to the idle level by a one-cycle `trail_o` strobe. The shift engine uses these strobes to launch and sample data.

When `active_i` drops, the current serial clock period is always completed first. The clock then parks at its idle level, so the serial bus never sees a shortened pulse. The same capture rule keeps settings written during an exchange from reaching the clock before the next exchange.

Top module: `spi_sclk_div`

## Requirements
- R1: With `ctl_i[12]`=1 (linear mode) and N=`ctl_i[7:0]`, `sclk_o` has a period of 2*(N+1) module clock cycles: each level lasts N+1 cycles.
- R2: With `ctl_i[12]`=0 (exponential mode) and N=`ctl_i[11:8]`, `sclk_o` has a period of 2^(N+1) module clock cycles: each level lasts 2^N cycles.
- R3: A linear divisor of 0 gives the fastest rate. `sclk_o` toggles every module clock cycle, for a period of 2.
- R4: The extreme settings give the largest ratios: a linear divisor of 255 gives a period of 512, and an exponential divisor of 15 gives a period of 65536.
- R5: After reset `sclk_o`, `lead_o` and `trail_o` are 0. While no exchange runs, `sclk_o` follows `cpol_i` one cycle late.
- R6: The first leading edge of an exchange appears one half period after the cycle in which `active_i` is first sampled high. `lead_o` is high for exactly the cycle in which `sclk_o` first shows the non-idle level. `trail_o` is high for exactly the cycle in which `sclk_o` returns to the idle level.
- R7: Changes to `ctl_i` during an exchange have no effect on that exchange. The new setting applies from the next exchange.
- R8: When `active_i` drops while `sclk_o` is at its non-idle level, the block completes that half period, emits `trail_o`, and then stops at the idle level. No further `lead_o` follows.
- R9: The idle polarity is captured at the start of an exchange. A change of `cpol_i` during the exchange does not alter the `sclk_o` waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_i | input | 13 | Clock control word: [7:0] linear divisor, [11:8] exponent, [12] mode (1 = linear) |
| cpol_i | input | 1 | Idle level of the serial clock |
| active_i | input | 1 | Exchange in progress; serial clock runs while set |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe on each leading edge of `sclk_o` |
| trail_o | output | 1 | One-cycle strobe on each trailing edge of `sclk_o` |

## Verification
A corrupted half-period shadow or counter shows up at the ports as a misplaced `lead_o` or `trail_o`. In the worst case this appears one half period after the fault, which is up to 32768 cycles at the slowest setting. A run flag that goes wrong shows up within one cycle, as `sclk_o` failing to follow `cpol_i` or as a truncated level when an exchange stops. The bench keeps a countdown model of the waveform and compares all three outputs on every cycle. It also measures periods and first-edge delays directly, in both laws and at both extremes.

// File: rtl/spi_sclk_div_pkg.sv
package spi_sclk_div_pkg;

  typedef enum logic {
    DIV_EXP = 1'b0,
    DIV_LIN = 1'b1
  } div_mode_e;

  // bits needed for a half period under either law
  function automatic int half_width(int lin_w, int exp_w);
    int lin_bits;
    int exp_bits;
    lin_bits = lin_w + 1;
    exp_bits = 1 << exp_w;
    return (lin_bits > exp_bits) ? lin_bits : exp_bits;
  endfunction

endpackage

// File: rtl/spi_sclk_div_cfg.sv
module spi_sclk_div_cfg
  import spi_sclk_div_pkg::*;
#(
  parameter int LIN_W  = 8,
  parameter int EXP_W  = 4,
  parameter int HALF_W = 16,
  localparam int CTL_W = LIN_W + EXP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CTL_W-1:0]  ctl_i,
  output logic [HALF_W-1:0] half_o
);

  logic [LIN_W-1:0]  lin_div;
  logic [EXP_W-1:0]  exp_div;
  div_mode_e         mode;
  logic [HALF_W-1:0] half_d;
  logic [HALF_W-1:0] half_q;

  assign lin_div = ctl_i[LIN_W-1:0];
  assign exp_div = ctl_i[LIN_W+:EXP_W];
  assign mode    = div_mode_e'(ctl_i[LIN_W+EXP_W]);

  always_comb begin
    if (mode == DIV_LIN) half_d = {{(HALF_W-LIN_W){1'b0}}, lin_div} + HALF_W'(1);
    else                 half_d = HALF_W'(1) << exp_div;
  end

  // shadow: only loaded on the first cycle of an exchange
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     half_q <= HALF_W'(1);
    else if (load_i) half_q <= half_d;
  end

  assign half_o = half_q;

endmodule

// File: rtl/spi_sclk_div_cnt.sv
module spi_sclk_div_cnt #(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tick_o,
  output logic [HALF_W-1:0] cnt_o
);

  logic [HALF_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i || clr_i)       cnt_q <= '0;
    else if (tick_o)                cnt_q <= '0;
    else                            cnt_q <= cnt_q + HALF_W'(1);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/spi_sclk_div_edge.sv
module spi_sclk_div_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic cpol_i,
  input  logic tick_i,
  output logic run_o,
  output logic start_o,
  output logic stop_o,
  output logic cpol_lat_o,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);

  logic run_q;
  logic cpol_q;
  logic sclk_q;
  logic lead_q;
  logic trail_q;
  logic at_idle;

  assign at_idle = (sclk_q == cpol_q);
  assign start_o = !run_q && active_i;
  // stop only from the idle level so no level is cut short
  assign stop_o  = run_q && !active_i && at_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cpol_q  <= 1'b0;
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      if (!run_q) begin
        sclk_q <= cpol_i;
        if (active_i) begin
          run_q  <= 1'b1;
          cpol_q <= cpol_i;
        end
      end else if (stop_o) begin
        run_q <= 1'b0;
      end else if (tick_i) begin
        sclk_q  <= ~sclk_q;
        lead_q  <= at_idle;
        trail_q <= !at_idle;
      end
    end
  end

  assign run_o      = run_q;
  assign cpol_lat_o = cpol_q;
  assign sclk_o     = sclk_q;
  assign lead_o     = lead_q;
  assign trail_o    = trail_q;

endmodule

// File: rtl/spi_sclk_div.sv
module spi_sclk_div
  import spi_sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CTL_W  = LIN_W + EXP_W + 1,
  localparam int HALF_W = half_width(LIN_W, EXP_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             cpol_i,
  input  logic             active_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);

  logic              run;
  logic              start;
  logic              stop;
  logic              tick;
  logic              cpol_lat;
  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] cnt;

  spi_sclk_div_cfg #(
    .LIN_W (LIN_W),
    .EXP_W (EXP_W),
    .HALF_W(HALF_W)
  ) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start),
    .ctl_i (ctl_i),
    .half_o(half)
  );

  spi_sclk_div_cnt #(
    .HALF_W(HALF_W)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .clr_i (stop),
    .half_i(half),
    .tick_o(tick),
    .cnt_o (cnt)
  );

  spi_sclk_div_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active_i),
    .cpol_i    (cpol_i),
    .tick_i    (tick),
    .run_o     (run),
    .start_o   (start),
    .stop_o    (stop),
    .cpol_lat_o(cpol_lat),
    .sclk_o    (sclk_o),
    .lead_o    (lead_o),
    .trail_o   (trail_o)
  );

endmodule

// File: rtl/spi_sclk_div_chk.sv
module spi_sclk_div_chk #(
  parameter int HALF_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic [HALF_W-1:0] half_i,
  input logic [HALF_W-1:0] cnt_i,
  input logic              cpol_lat_i,
  input logic              sclk_i,
  input logic              lead_i,
  input logic              trail_i
);

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_i && trail_i)); // R6

  AST_LEAD_AWAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_i |-> (sclk_i != cpol_lat_i)); // R6

  AST_TRAIL_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_i |-> (sclk_i == cpol_lat_i)); // R6

  AST_EDGE_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && (sclk_i != $past(sclk_i))) |-> (lead_i || trail_i)); // R6

  AST_STOP_AT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_i) |-> (sclk_i == cpol_lat_i)); // R8

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> $stable(half_i)); // R7

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i < half_i)); // R1

  AST_HALF_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_i != '0); // R4

endmodule

bind spi_sclk_div spi_sclk_div_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run),
  .half_i    (half),
  .cnt_i     (cnt),
  .cpol_lat_i(cpol_lat),
  .sclk_i    (sclk_o),
  .lead_i    (lead_o),
  .trail_i   (trail_o)
);

// File: tb/spi_sclk_div_tb.sv
module spi_sclk_div_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] ctl_i = '0;
  logic        cpol_i = 1'b0;
  logic        active_i = 1'b0;
  logic        sclk_o;
  logic        lead_o;
  logic        trail_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_req = "R5";

  // reference model state
  bit m_run = 0, m_sclk = 0, m_cpol = 0, m_lead = 0, m_trail = 0;
  int m_half = 1, m_left = 0;

  spi_sclk_div u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctl_i   (ctl_i),
    .cpol_i  (cpol_i),
    .active_i(active_i),
    .sclk_o  (sclk_o),
    .lead_o  (lead_o),
    .trail_o (trail_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [12:0] lin_ctl(int n);
    return {1'b1, 4'h0, 8'(n)};
  endfunction

  function automatic logic [12:0] exp_ctl(int n);
    return {1'b0, 4'(n), 8'h00};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // countdown model of the serial clock
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_sclk = 0; m_cpol = 0; m_lead = 0; m_trail = 0;
      m_half = 1; m_left = 0;
    end else begin
      m_lead = 0;
      m_trail = 0;
      if (!m_run) begin
        m_sclk = cpol_i;
        if (active_i) begin
          m_run  = 1;
          m_cpol = cpol_i;
          m_half = ctl_i[12] ? int'(ctl_i[7:0]) + 1 : (1 << ctl_i[11:8]);
          m_left = m_half;
        end
      end else if (!active_i && m_sclk == m_cpol) begin
        m_run = 0;
      end else begin
        m_left--;
        if (m_left == 0) begin
          if (m_sclk == m_cpol) m_lead = 1;
          else                  m_trail = 1;
          m_sclk = !m_sclk;
          m_left = m_half;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(sclk_o == m_sclk, {cur_req, " sclk"}, sclk_o, m_sclk);
      chk(lead_o == m_lead, {cur_req, " lead"}, lead_o, m_lead);
      chk(trail_o == m_trail, {cur_req, " trail"}, trail_o, m_trail);
    end
  end

  task automatic wait_idle();
    active_i = 1'b0;
    while (m_run) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // start an exchange, check first-lead delay and lead-to-lead period
  task automatic measure(logic [12:0] ctl, bit pol, int nlead, int half,
                         string req, bit mid_chg, logic [12:0] ctl_mid);
    int k;
    int seen;
    int prev;
    @(negedge clk_i);
    ctl_i = ctl; cpol_i = pol; active_i = 1'b1;
    k = 0; seen = 0; prev = 0;
    while (seen < nlead) begin
      @(negedge clk_i);
      k++;
      if (lead_o) begin
        if (seen == 0) chk(k == half + 1, {req, " R6 first lead"}, k, half + 1);
        else           chk(k - prev == 2 * half, {req, " period"}, k - prev, 2 * half);
        if (seen == 0 && mid_chg) ctl_i = ctl_mid;
        prev = k;
        seen++;
      end
    end
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R5 reset state
    chk(sclk_o == 1'b0, "R5 reset sclk", sclk_o, 0);
    chk(lead_o == 1'b0, "R5 reset lead", lead_o, 0);
    chk(trail_o == 1'b0, "R5 reset trail", trail_o, 0);

    cur_req = "R5";
    cpol_i = 1'b1;
    @(negedge clk_i);
    chk(sclk_o == 1'b1, "R5 idle follows cpol", sclk_o, 1);
    cpol_i = 1'b0;
    @(negedge clk_i);
    chk(sclk_o == 1'b0, "R5 idle follows cpol", sclk_o, 0);

    cur_req = "R1";
    measure(lin_ctl(3), 1'b0, 4, 4, "R1 lin3", 1'b0, '0);
    measure(lin_ctl(6), 1'b1, 3, 7, "R1 lin6 cpol1", 1'b0, '0);
    cur_req = "R3";
    measure(lin_ctl(0), 1'b0, 5, 1, "R3 lin0", 1'b0, '0);
    cur_req = "R2";
    measure(exp_ctl(2), 1'b0, 3, 4, "R2 exp2", 1'b0, '0);
    measure(exp_ctl(0), 1'b1, 3, 1, "R2 exp0", 1'b0, '0);
    measure(exp_ctl(5), 1'b0, 2, 32, "R2 exp5", 1'b0, '0);

    cur_req = "R7";
    measure(lin_ctl(1), 1'b0, 3, 2, "R7 mid change ignored", 1'b1, lin_ctl(5));
    measure(lin_ctl(5), 1'b0, 2, 6, "R7 next exchange", 1'b0, '0);

    // R8: drop active while sclk is at non-idle level
    cur_req = "R8";
    begin
      int k;
      int trail_k;
      int leads;
      @(negedge clk_i);
      ctl_i = lin_ctl(3); cpol_i = 1'b0; active_i = 1'b1;
      while (!lead_o) @(negedge clk_i);
      active_i = 1'b0;
      trail_k = 0; leads = 0;
      for (int i = 1; i <= 20; i++) begin
        @(negedge clk_i);
        if (trail_o && trail_k == 0) trail_k = i;
        if (lead_o) leads++;
        if (trail_k == 0) chk(sclk_o == 1'b1, "R8 level held", sclk_o, 1);
      end
      chk(trail_k == 4, "R8 trail after full half", trail_k, 4);
      chk(leads == 0, "R8 no lead after stop", leads, 0);
      chk(sclk_o == 1'b0, "R8 parked idle", sclk_o, 0);
      k = 0;
    end

    // R9: cpol change during exchange
    cur_req = "R9";
    begin
      int trails;
      @(negedge clk_i);
      ctl_i = lin_ctl(1); cpol_i = 1'b1; active_i = 1'b1;
      @(negedge clk_i);
      cpol_i = 1'b0;
      trails = 0;
      while (trails < 2) begin
        @(negedge clk_i);
        if (trail_o) begin
          trails++;
          chk(sclk_o == 1'b1, "R9 trail returns to latched idle", sclk_o, 1);
        end
      end
      wait_idle();
      chk(sclk_o == 1'b0, "R5 idle after exchange follows cpol", sclk_o, 0);
    end

    cur_req = "R4";
    measure(lin_ctl(255), 1'b0, 2, 256, "R4 lin255", 1'b0, '0);
    measure(exp_ctl(15), 1'b0, 2, 32768, "R4 exp15", 1'b0, '0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule